// File: doc/BRIEF.md
# Terminator-delimited packet forwarding buffer

The block gathers bytes from a byte-wide receive stream into local storage until the end-of-packet byte 0x65 shows up. Once that byte is stored the packet is complete and the block hands it, byte by byte and in arrival order, to a downstream serial transmitter that reports its state on a busy line. When the transmitter has finished the last byte, the status clears and the next packet may be captured.

The receive side is a valid strobe plus an 8-bit data bus. It has no ready signal and cannot apply back-pressure: a byte offered while a finished packet is still waiting or draining is dropped, and a packet that outgrows the storage is thrown away and capture starts again. On the transmit side the block raises a one-cycle send strobe with the byte on `tx_data`, but only while `tx_busy` is low. After that it stays quiet until the transmitter has raised busy and then lowered it again. A 16-bit status word reports the stored length and a completion flag.

Top module: `pfb_fwd_buf`

## Requirements
- R1: Each accepted byte is written at the slot equal to the current stored count, and the count in status bits 13:0 then goes up by one on the clock edge that samples `in_valid`.
- R2: The byte 0x65 is stored and counted as the final byte of the packet and sets status bit 15 on the same edge.
- R3: While status bit 15 is set, bytes offered on the input are neither stored nor counted and never appear on the transmit side.
- R4: If the count reaches 200 without a 0x65, the count returns to 0 and the next byte is stored at slot 0 of a fresh packet. The stored count never exceeds 200.
- R5: The end byte is tested before the capacity limit, so a 0x65 arriving as byte 200 completes a 200-byte packet.
- R6: A completed packet is sent from slot 0 up to slot length-1, one byte for each `tx_send` strobe, and each strobe lasts exactly one cycle.
- R7: `tx_send` is raised only in a cycle that follows a cycle with `tx_busy` low. No second strobe is issued until `tx_busy` has been seen high and then low.
- R8: On the edge where the transmitter's busy is first seen low after the last byte, the whole status word becomes zero.
- R9: A byte offered on that same clearing edge is captured as slot 0 of the new packet, so status reads a count of 1.
- R10: A synchronous active-low reset clears the count, the completion flag and the drain position, and holds `tx_send` low.
- R11: Status layout: bit 15 is the completion flag, bits 13:0 are the stored count, and bit 14 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Receive byte strobe |
| in_data | input | 8 | Receive byte |
| tx_busy | input | 1 | Downstream transmitter is shifting a byte |
| tx_send | output | 1 | One-cycle request to send `tx_data` |
| tx_data | output | 8 | Byte offered to the transmitter |
| status | output | 16 | Completion flag and stored count |

## Verification
The bench targets the places where the count and the flag are easiest to get wrong. A 0x65 landing in slot 199 must complete the packet and must not restart capture. A 200th plain byte must wrap the count to zero. Bytes offered while the flag is set must be dropped, and a design that stored them would stretch the next packet or corrupt it. A byte arriving exactly on the clearing edge must become slot 0; a design that lost it would read count 0, and one that appended it to the old packet would read the wrong length. A transmitter model flags any strobe issued before its busy pulse has ended, which catches a drain that skips waiting for busy to rise and so sends bytes twice or back to back.

// File: rtl/pfb_pkg.sv
package pfb_pkg;
  localparam int STAT_W = 16;
  localparam int LEN_W  = 14;

  typedef enum logic [1:0] {
    DR_IDLE    = 2'd0,
    DR_WAIT_HI = 2'd1,
    DR_WAIT_LO = 2'd2
  } drain_st_t;
endpackage

// File: rtl/pfb_store.sv
module pfb_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 200,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/pfb_capture.sv
module pfb_capture #(
  parameter int          DW   = 8,
  parameter int          CAP  = 200,
  parameter logic [DW-1:0] TERM = 8'h65,
  parameter int          CW   = $clog2(CAP + 1),
  parameter int          AW   = $clog2(CAP)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          clr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [CW-1:0] count,
  output logic          done
);
  logic [CW-1:0] base_cnt;
  logic [CW-1:0] nxt_cnt;
  logic          base_done;
  logic          take;

  // A clear from the drain side frees the buffer in the same cycle.
  assign base_cnt  = clr ? '0 : count;
  assign base_done = clr ? 1'b0 : done;
  assign take      = in_valid && !base_done;
  assign nxt_cnt   = base_cnt + CW'(1);
  assign wr_en     = take;
  assign wr_addr   = base_cnt[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      done  <= 1'b0;
    end else if (take) begin
      if (in_data == TERM) begin
        count <= nxt_cnt;
        done  <= 1'b1;
      end else if (nxt_cnt >= CW'(CAP)) begin
        count <= '0;
        done  <= 1'b0;
      end else begin
        count <= nxt_cnt;
        done  <= 1'b0;
      end
    end else if (clr) begin
      count <= '0;
      done  <= 1'b0;
    end
  end
endmodule

// File: rtl/pfb_drain.sv
module pfb_drain
  import pfb_pkg::*;
#(
  parameter int DW  = 8,
  parameter int CAP = 200,
  parameter int CW  = $clog2(CAP + 1),
  parameter int AW  = $clog2(CAP)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done,
  input  logic [CW-1:0] count,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  input  logic          tx_busy,
  output logic          tx_send,
  output logic [DW-1:0] tx_data,
  output logic          clr
);
  drain_st_t     st;
  logic [CW-1:0] ptr;
  logic          last;

  assign rd_addr = ptr[AW-1:0];
  assign last    = (ptr + CW'(1)) == count;
  assign clr     = (st == DR_WAIT_LO) && !tx_busy && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= DR_IDLE;
      ptr     <= '0;
      tx_send <= 1'b0;
      tx_data <= '0;
    end else begin
      tx_send <= 1'b0;
      case (st)
        DR_IDLE: begin
          if (done && !tx_busy) begin
            tx_send <= 1'b1;
            tx_data <= rd_data;
            st      <= DR_WAIT_HI;
          end
        end
        DR_WAIT_HI: begin
          if (tx_busy) st <= DR_WAIT_LO;
        end
        DR_WAIT_LO: begin
          if (!tx_busy) begin
            st  <= DR_IDLE;
            ptr <= last ? '0 : ptr + CW'(1);
          end
        end
        default: st <= DR_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pfb_fwd_buf.sv
module pfb_fwd_buf
  import pfb_pkg::*;
#(
  parameter int          DW   = 8,
  parameter int          CAP  = 200,
  parameter logic [7:0]  TERM = 8'h65
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DW-1:0]     in_data,
  input  logic              tx_busy,
  output logic              tx_send,
  output logic [DW-1:0]     tx_data,
  output logic [STAT_W-1:0] status
);
  localparam int CW = $clog2(CAP + 1);
  localparam int AW = $clog2(CAP);

  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;
  logic [CW-1:0] count;
  logic          done;
  logic          drain_clr;

  pfb_capture #(.DW(DW), .CAP(CAP), .TERM(DW'(TERM)), .CW(CW), .AW(AW)) u_cap (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .clr(drain_clr), .wr_en(wr_en), .wr_addr(wr_addr), .count(count), .done(done)
  );

  pfb_store #(.DW(DW), .DEPTH(CAP), .AW(AW)) u_store (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(in_data),
    .raddr(rd_addr), .rdata(rd_data)
  );

  pfb_drain #(.DW(DW), .CAP(CAP), .CW(CW), .AW(AW)) u_drain (
    .clk(clk), .rst_n(rst_n), .done(done), .count(count),
    .rd_addr(rd_addr), .rd_data(rd_data), .tx_busy(tx_busy),
    .tx_send(tx_send), .tx_data(tx_data), .clr(drain_clr)
  );

  assign status = {done, 1'b0, LEN_W'(count)};
endmodule

// File: rtl/pfb_checker.sv
module pfb_checker #(
  parameter int         CAP  = 200,
  parameter logic [7:0] TERM = 8'h65
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [7:0]  in_data,
  input logic        tx_busy,
  input logic        tx_send,
  input logic [15:0] status,
  input logic        clr
);
  assert_end_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[15]) |-> $past(in_valid && in_data == TERM));

  assert_hold_while_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (status[15] && $past(status[15]) && !$past(clr)) |-> $stable(status[13:0]));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    status[13:0] <= 14'(CAP));

  assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_send |=> !tx_send);

  assert_strobe_not_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_send |-> !$past(tx_busy));

  assert_clear_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[15]) |-> status[13:0] <= 14'd1);

  assert_reset_clears_R10: assert property (@(posedge clk)
    !rst_n |=> (status == 16'h0000 && !tx_send));
endmodule

bind pfb_fwd_buf pfb_checker #(.CAP(CAP), .TERM(TERM)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
  .tx_busy(tx_busy), .tx_send(tx_send), .status(status), .clr(drain_clr)
);

// File: tb/tb_pfb_fwd_buf.sv
`timescale 1ns/1ps
module tb_pfb_fwd_buf;
  localparam int CAP      = 200;
  localparam int BUSY_LEN = 4;
  localparam int WD_LIMIT = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        hold = 1'b0;
  logic        mbusy;
  logic        tx_busy;
  logic        tx_send;
  logic [7:0]  tx_data;
  logic [15:0] status;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int viol = 0;
  int got_n = 0;
  int bcnt = 0;
  logic pending;
  logic [7:0] got [1024];
  logic [7:0] exp_b [256];

  always #4 clk = ~clk;

  assign tx_busy = mbusy | hold;

  pfb_fwd_buf dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .tx_busy(tx_busy), .tx_send(tx_send), .tx_data(tx_data), .status(status)
  );

  // Transmitter model: busy rises the edge after a strobe and lasts BUSY_LEN cycles.
  always @(posedge clk) begin
    if (!rst_n) begin
      mbusy   <= 1'b0;
      bcnt    <= 0;
      pending <= 1'b0;
    end else if (tx_send) begin
      if (pending) viol <= viol + 1;
      pending      <= 1'b1;
      got[got_n]   <= tx_data;
      got_n        <= got_n + 1;
      mbusy        <= 1'b1;
      bcnt         <= BUSY_LEN;
    end else if (bcnt > 1) begin
      bcnt <= bcnt - 1;
    end else if (mbusy) begin
      mbusy   <= 1'b0;
      pending <= 1'b0;
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WD_LIMIT) begin
      checks = checks + 1;
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WD_LIMIT);
      summary();
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic put_byte(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_clear();
    int n = 0;
    while (status != 16'h0000 && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic compare_pkt(input string req, input int start, input int len);
    int bad = -1;
    for (int i = 0; i < len; i++) begin
      if (bad < 0 && got[start + i] !== exp_b[i]) bad = i;
    end
    check({req, " length"}, got_n - start, len);
    if (bad >= 0) check({req, " byte"}, {24'h0, got[start + bad]}, {24'h0, exp_b[bad]});
    else check({req, " bytes"}, 0, 0);
    check("R7 handshake", viol, 0);
  endtask

  task automatic t_reset();
    check("R10 reset status", status, 16'h0000);
    check("R10 reset strobe", tx_send, 1'b0);
  endtask

  task automatic t_basic();
    int s = got_n;
    exp_b[0] = 8'hA1; exp_b[1] = 8'hA2; exp_b[2] = 8'hA3; exp_b[3] = 8'h65;
    for (int i = 0; i < 3; i++) begin
      put_byte(exp_b[i]);
      check("R1 count step", status, 16'(i + 1));
    end
    put_byte(8'h65);
    check("R2 R11 terminator completes", status, 16'h8004);
    wait_clear();
    check("R8 status cleared", status, 16'h0000);
    compare_pkt("R6 basic drain", s, 4);
  endtask

  task automatic t_ignore();
    int s = got_n;
    hold = 1'b1;
    exp_b[0] = 8'h10; exp_b[1] = 8'h65;
    put_byte(8'h10);
    put_byte(8'h65);
    check("R2 second packet", status, 16'h8002);
    put_byte(8'h11);
    put_byte(8'h65);
    check("R3 input ignored", status, 16'h8002);
    hold = 1'b0;
    wait_clear();
    repeat (20) @(negedge clk);
    check("R3 nothing queued", status, 16'h0000);
    compare_pkt("R3 drain", s, 2);
  endtask

  task automatic t_overflow();
    int s;
    for (int i = 0; i < CAP - 1; i++) put_byte(8'h80 | 8'(i & 8'h3F));
    check("R4 count at 199", status, 16'(CAP - 1));
    put_byte(8'h81);
    check("R4 overflow restart", status, 16'h0000);
    s = got_n;
    exp_b[0] = 8'h21; exp_b[1] = 8'h65;
    put_byte(8'h21);
    put_byte(8'h65);
    check("R4 fresh packet", status, 16'h8002);
    wait_clear();
    compare_pkt("R4 drain", s, 2);
  endtask

  task automatic t_full();
    int s = got_n;
    for (int i = 0; i < CAP - 1; i++) begin
      exp_b[i] = 8'(i) ^ 8'hC3;
      if (exp_b[i] == 8'h65) exp_b[i] = 8'h00;
      put_byte(exp_b[i]);
    end
    exp_b[CAP - 1] = 8'h65;
    put_byte(8'h65);
    check("R5 terminator in last slot", status, 16'h8000 | 16'(CAP));
    wait_clear();
    compare_pkt("R5 R6 full drain", s, CAP);
  endtask

  task automatic t_same_cycle();
    int s = got_n;
    put_byte(8'h31);
    put_byte(8'h65);
    while (got_n < s + 2) @(negedge clk);
    while (tx_busy) @(negedge clk);
    in_valid = 1'b1;
    in_data  = 8'h42;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 byte on clear edge", status, 16'h0001);
    s = got_n;
    exp_b[0] = 8'h42; exp_b[1] = 8'h65;
    put_byte(8'h65);
    check("R9 new packet", status, 16'h8002);
    wait_clear();
    compare_pkt("R9 drain", s, 2);
  endtask

  task automatic t_reset_mid();
    put_byte(8'h01);
    put_byte(8'h02);
    check("R1 partial", status, 16'h0002);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 mid reset", status, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 after reset", status, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_basic();
    t_ignore();
    t_overflow();
    t_full();
    t_same_cycle();
    t_reset_mid();
    summary();
    $finish;
  end
endmodule